// File: doc/BRIEF.md
# Password Gate Controller

This block decides whether debug and in-system programming services may touch program memory. It holds two lock levels. The password lock comes up set after power-on reset. It is cleared only when a caller shifts in sixteen 16-bit words that equal the sixteen program-memory words kept at addresses 0x010 to 0x01F. The code lock sits above it. While the code lock is set, access is refused whatever the caller supplies. Only a mass erase of the program memory releases the code lock, and after that erase the stored password reads as all zeros.

Words arrive one per cycle from the port logic, with a valid strobe. The block keeps an index of the word it expects next. For each accepted word it issues one read of the matching password address on a simple synchronous read port. It compares the supplied word with the returned word one cycle later. One mismatch anywhere spoils the whole attempt, but the verdict appears only after the sixteenth word has been compared. A start pulse opens an attempt, and a new start always rewinds to word 0.

Top module: `pw_gate_ctrl`

## Requirements
- R1: After reset, `pass_lock`=1, `code_lock`=0, `busy`=0, `done`=0, `pass`=0 and `access_granted`=0.
- R2: The n-th word accepted in an attempt (n = 0..15) raises `mem_rd_en` in the same cycle, with `mem_rd_addr` = 0x010 + n. `mem_rd_en` is never raised in any other cycle.
- R3: `busy` is 1 from the cycle after an `att_start` pulse. `done` is a one-cycle pulse, two cycles after the cycle that carried the sixteenth word, and `busy` is 0 in that same cycle.
- R4: When all sixteen supplied words equal the stored words and no code lock applies, `pass`=1 with `done`, `pass_lock` clears in that cycle, and `access_granted` becomes 1.
- R5: If any single supplied word differs from its stored word, the attempt reports `pass`=0 and `pass_lock` does not change.
- R6: Once cleared, `pass_lock` stays 0 until the next reset, whatever later attempts report. While both locks are 0, `access_granted` is 1 with no password supplied.
- R7: A `code_lock_set` pulse sets `code_lock`. While `code_lock` is 1, `access_granted` is 0 and every attempt reports `pass`=0 with `pass_lock` unchanged. A `code_lock_set` in the final compare cycle also defeats that attempt.
- R8: A `mass_erase` pulse clears `code_lock` and abandons any attempt (`busy`=0 next cycle, no `done`). It takes priority over `att_start` and `code_lock_set` in the same cycle. An all-zero password then passes against the erased memory.
- R9: An `att_start` while `busy` discards the words already received and restarts the comparison at word 0 (address 0x010).
- R10: A word is ignored (no read, no effect on the verdict) when it arrives while the block is idle, in the start cycle, or after the sixteenth word of the attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| att_start | input | 1 | Opens or restarts an attempt |
| att_valid | input | 1 | Supplied word is valid this cycle |
| att_word | input | 16 | Supplied password word |
| code_lock_set | input | 1 | Sets the code lock |
| mass_erase | input | 1 | Mass-erase event: clears the code lock and aborts any attempt |
| mem_rd_en | output | 1 | Read request to program memory |
| mem_rd_addr | output | 10 | Word address of the read |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Verdict of the last finished attempt |
| pass_lock | output | 1 | Password lock bit |
| code_lock | output | 1 | Code lock bit |
| access_granted | output | 1 | Debug and programming access allowed |

## Verification
The closest same-cycle collision is a `code_lock_set` in the cycle where the sixteenth compare fires. The bench provokes it with a fully correct password. It expects `pass`=0, `pass_lock` still 1 and `code_lock` 1, so the lock must win over the verdict. A second collision is a `mass_erase` together with `code_lock_set`. The bench expects the code lock to stay clear and the attempt in flight to vanish with no `done`. A restart that lands in the final compare cycle is judged by a later attempt: its result must depend only on the sixteen words sent after the restart.

// File: rtl/pw_gate_pkg.sv
package pw_gate_pkg;

  typedef enum logic [1:0] {
    GATE_IDLE    = 2'd0,
    GATE_COLLECT = 2'd1,
    GATE_DRAIN   = 2'd2
  } gate_state_t;

  // Address of password word idx when the password starts at base.
  function automatic int word_addr(input int base, input int idx);
    return base + idx;
  endfunction

  // Non-zero when two words disagree in any bit.
  function automatic logic words_differ(input logic [15:0] a, input logic [15:0] b);
    return |(a ^ b);
  endfunction

  // Running mismatch: a first word starts a fresh accumulation.
  function automatic logic miss_next(input logic first, input logic acc, input logic diff);
    return (first ? 1'b0 : acc) | diff;
  endfunction

endpackage

// File: rtl/pw_gate_seq.sv
module pw_gate_seq
  import pw_gate_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int PW_BASE  = 16,
  parameter int PW_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              erase,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word_in,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              accept,
  output logic              cmp_fire,
  output logic              cmp_first,
  output logic              cmp_last,
  output logic [DATA_W-1:0] held_word
);

  localparam int IDX_W = $clog2(PW_WORDS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PW_WORDS - 1);

  gate_state_t       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pend_q;
  logic              first_q;
  logic              last_q;

  assign accept    = (state_q == GATE_COLLECT) && word_vld && !start && !erase;
  assign rd_en     = accept;
  assign rd_addr   = ADDR_W'(word_addr(PW_BASE, int'(idx_q)));
  assign busy      = (state_q != GATE_IDLE);
  assign cmp_fire  = pend_q && !start && !erase;
  assign cmp_first = first_q;
  assign cmp_last  = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= GATE_IDLE;
      idx_q     <= '0;
      pend_q    <= 1'b0;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      held_word <= '0;
    end else if (erase) begin
      state_q <= GATE_IDLE;
      pend_q  <= 1'b0;
    end else if (start) begin
      state_q <= GATE_COLLECT;
      idx_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= accept;
      if (accept) begin
        held_word <= word_in;
        first_q   <= (idx_q == '0);
        last_q    <= (idx_q == LAST_IDX);
        idx_q     <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) state_q <= GATE_DRAIN;
      end
      if (state_q == GATE_DRAIN && cmp_fire && last_q) state_q <= GATE_IDLE;
    end
  end

endmodule

// File: rtl/pw_gate_cmp.sv
module pw_gate_cmp
  import pw_gate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_fire,
  input  logic              cmp_first,
  input  logic              cmp_last,
  input  logic [DATA_W-1:0] held_word,
  input  logic [DATA_W-1:0] mem_word,
  output logic              fin,
  output logic              fin_ok
);

  logic miss_q;
  logic diff;
  logic miss_now;

  assign diff     = words_differ(16'(held_word), 16'(mem_word));
  assign miss_now = miss_next(cmp_first, miss_q, diff);
  assign fin      = cmp_fire && cmp_last;
  assign fin_ok   = !miss_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        miss_q <= 1'b0;
    else if (cmp_fire) miss_q <= miss_now;
  end

endmodule

// File: rtl/pw_gate_locks.sv
module pw_gate_locks (
  input  logic clk,
  input  logic rst_n,
  input  logic fin,
  input  logic fin_ok,
  input  logic cl_set,
  input  logic erase,
  output logic pass_lock,
  output logic code_lock,
  output logic done,
  output logic pass,
  output logic unlock_evt
);

  logic cl_now;

  assign cl_now     = code_lock | (cl_set & !erase);
  assign unlock_evt = fin && fin_ok && !cl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_lock <= 1'b1;
      code_lock <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
    end else begin
      done <= fin;
      if (fin) pass <= unlock_evt;
      if (unlock_evt) pass_lock <= 1'b0;
      if (erase)       code_lock <= 1'b0;
      else if (cl_set) code_lock <= 1'b1;
    end
  end

endmodule

// File: rtl/pw_gate_ctrl.sv
module pw_gate_ctrl
  import pw_gate_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int PW_BASE  = 16,
  parameter int PW_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              att_start,
  input  logic              att_valid,
  input  logic [DATA_W-1:0] att_word,
  input  logic              code_lock_set,
  input  logic              mass_erase,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              pass_lock,
  output logic              code_lock,
  output logic              access_granted
);

  logic              seq_accept;
  logic              cmp_fire;
  logic              cmp_first;
  logic              cmp_last;
  logic [DATA_W-1:0] held_word;
  logic              fin;
  logic              fin_ok;
  logic              unlock_evt;

  pw_gate_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PW_BASE(PW_BASE), .PW_WORDS(PW_WORDS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(att_start), .erase(mass_erase),
    .word_vld(att_valid), .word_in(att_word),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .busy(busy),
    .accept(seq_accept), .cmp_fire(cmp_fire), .cmp_first(cmp_first),
    .cmp_last(cmp_last), .held_word(held_word)
  );

  pw_gate_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_fire(cmp_fire), .cmp_first(cmp_first),
    .cmp_last(cmp_last), .held_word(held_word), .mem_word(mem_rd_data),
    .fin(fin), .fin_ok(fin_ok)
  );

  pw_gate_locks u_locks (
    .clk(clk), .rst_n(rst_n), .fin(fin), .fin_ok(fin_ok),
    .cl_set(code_lock_set), .erase(mass_erase),
    .pass_lock(pass_lock), .code_lock(code_lock), .done(done), .pass(pass),
    .unlock_evt(unlock_evt)
  );

  assign access_granted = !pass_lock && !code_lock;

endmodule

// File: rtl/pw_gate_ctrl_chk.sv
module pw_gate_ctrl_chk #(
  parameter int ADDR_W   = 10,
  parameter int PW_BASE  = 16,
  parameter int PW_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              att_start,
  input logic              mass_erase,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              pass_lock,
  input logic              code_lock,
  input logic              access_granted,
  input logic              seq_accept,
  input logic              unlock_evt
);

  AST_CODE_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    code_lock |-> !access_granted);  // R7

  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (int'(mem_rd_addr) >= PW_BASE && int'(mem_rd_addr) < PW_BASE + PW_WORDS));  // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R3

  AST_LOCK_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_lock |=> !pass_lock);  // R6

  AST_ERASE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase |=> (!code_lock && !busy && !done));  // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (att_start && !mass_erase) |=> busy);  // R9

  AST_UNLOCK_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_lock) |-> (done && pass));  // R4

  AST_FAIL_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> $stable(pass_lock));  // R5

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !seq_accept));  // R10

  AST_UNLOCK_WITHOUT_CL: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> !code_lock);  // R7

endmodule

bind pw_gate_ctrl pw_gate_ctrl_chk #(
  .ADDR_W(ADDR_W), .PW_BASE(PW_BASE), .PW_WORDS(PW_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .att_start(att_start), .mass_erase(mass_erase),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .busy(busy), .done(done),
  .pass(pass), .pass_lock(pass_lock), .code_lock(code_lock),
  .access_granted(access_granted), .seq_accept(seq_accept), .unlock_evt(unlock_evt)
);

// File: tb/pw_gate_ctrl_tb.sv
module pw_gate_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        att_start = 1'b0;
  logic        att_valid = 1'b0;
  logic [15:0] att_word = '0;
  logic        code_lock_set = 1'b0;
  logic        mass_erase = 1'b0;
  logic        mem_rd_en;
  logic [9:0]  mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        busy, done, pass, pass_lock, code_lock, access_granted;

  logic [15:0] pw_mem [16];
  logic [15:0] sup [16];
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pw_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .att_start(att_start), .att_valid(att_valid),
    .att_word(att_word), .code_lock_set(code_lock_set), .mass_erase(mass_erase),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .pass(pass), .pass_lock(pass_lock),
    .code_lock(code_lock), .access_granted(access_granted)
  );

  // Program memory model: one-cycle read latency.
  always @(posedge clk) begin
    if (mem_rd_en) begin
      if (mem_rd_addr >= 10'd16 && mem_rd_addr < 10'd32) mem_rd_data <= pw_mem[mem_rd_addr - 10'd16];
      else mem_rd_data <= 16'hBAD0;
    end
  end

  function automatic bit exp_verdict(input logic [15:0] s [16], input logic [15:0] m [16], input bit cl);
    bit ok = !cl;
    for (int i = 0; i < 16; i++) if (s[i] != m[i]) ok = 0;
    return ok;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 0; att_start = 0; att_valid = 0; code_lock_set = 0; mass_erase = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_cl();
    @(negedge clk); code_lock_set = 1;
    @(negedge clk); code_lock_set = 0;
  endtask

  // Full attempt: start, 16 words, optional lock in final compare cycle,
  // optional extra word after the sixteenth.
  task automatic attempt(input bit cl_final, input bit extra, input bit exp_p, input string tag);
    @(negedge clk); att_start = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      att_start = 0; att_valid = 1; att_word = sup[i];
      #1;
      if (i == 0) chk("R3 busy after start", busy, 1);
      chk("R2 read request", {mem_rd_en, mem_rd_addr}, {1'b1, 10'(16 + i)});
    end
    @(negedge clk);
    att_valid = extra; att_word = 16'h5A5A; code_lock_set = cl_final;
    #1;
    if (extra) chk("R10 word after sixteenth", mem_rd_en, 0);
    chk("R3 no early done", done, 0);
    @(negedge clk);
    att_valid = 0; code_lock_set = 0;
    chk("R3 done pulse", {done, busy}, 2'b10);
    chk(tag, pass, exp_p);
    @(negedge clk);
    chk("R3 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) pw_mem[i] = 16'h1000 + 16'(i * 37);
    por();
    chk("R1 reset state", {pass_lock, code_lock, busy, done, pass, access_granted}, 6'b100000);

    // R10: word while idle is ignored
    @(negedge clk); att_valid = 1; att_word = 16'h1234; #1;
    chk("R10 idle read", mem_rd_en, 0);
    @(negedge clk); att_valid = 0;
    @(negedge clk); chk("R10 idle no effect", {busy, done, pass_lock}, 3'b001);

    // R5: one wrong word
    for (int i = 0; i < 16; i++) sup[i] = pw_mem[i];
    sup[15] = sup[15] ^ 16'h0001;
    attempt(0, 0, exp_verdict(sup, pw_mem, 0), "R5 mismatch verdict");
    chk("R5 lock kept", pass_lock, 1);

    // R7: lock arrives in final compare cycle with a correct password
    for (int i = 0; i < 16; i++) sup[i] = pw_mem[i];
    attempt(1, 1, 0, "R7 same-cycle lock verdict");
    chk("R7 locks", {pass_lock, code_lock, access_granted}, 3'b110);
    attempt(0, 0, 0, "R7 locked correct password");

    // R8: erase together with lock set, attempt abort
    @(negedge clk); att_start = 1;
    @(negedge clk); att_start = 0; att_valid = 1; att_word = pw_mem[0];
    @(negedge clk); att_valid = 0; mass_erase = 1; code_lock_set = 1;
    for (int i = 0; i < 16; i++) pw_mem[i] = 16'h0000;
    @(negedge clk); mass_erase = 0; code_lock_set = 0;
    chk("R8 erase clears", {code_lock, busy}, 2'b00);
    repeat (3) @(negedge clk);
    chk("R8 no done after abort", done, 0);

    // R9: restart mid-sequence discards wrong words, zero password passes
    @(negedge clk); att_start = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); att_start = 0; att_valid = 1; att_word = 16'hFFFF;
    end
    @(negedge clk); att_valid = 0;
    for (int i = 0; i < 16; i++) sup[i] = 16'h0000;
    attempt(0, 0, 1, "R9 restart then R8 zero password passes");
    chk("R4 unlocked", {pass_lock, access_granted}, 2'b01);

    // R6: sticky clear, wrong attempt does not relock
    sup[3] = 16'h0040;
    attempt(0, 0, 0, "R6 wrong after unlock");
    chk("R6 still open", {pass_lock, access_granted}, 2'b01);

    // Random trials
    for (int t = 0; t < 30; t++) begin
      int mode = int'($urandom % 3);
      int bad  = int'($urandom % 16);
      bit cl;
      por();
      for (int i = 0; i < 16; i++) begin
        pw_mem[i] = 16'($urandom);
        sup[i] = pw_mem[i];
      end
      if (mode == 1) sup[bad] = sup[bad] ^ (16'($urandom) | 16'h0100);
      cl = (mode == 2);
      if (cl) pulse_cl();
      attempt(0, 0, exp_verdict(sup, pw_mem, cl), mode == 0 ? "R4 random pass" : (mode == 1 ? "R5 random mismatch" : "R7 random locked"));
      chk("R4 lock state", pass_lock, !exp_verdict(sup, pw_mem, cl));
      chk("R7 access", access_granted, exp_verdict(sup, pw_mem, cl));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule